// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

A synchronous up counter, `W` bits wide (four by default). One rising edge updates every state bit, so no bit is clocked from another. Each edge either clears the counter, copies a parallel data word into it, adds one, or holds the value. Two count enables must both be high for the counter to advance: a local enable `cnt_en_a`, and a chain enable `cnt_en_b` that also gates the terminal-count output.

A compile-time parameter picks how clear behaves. In `CLR_SYNC` mode the clear takes effect on the next rising edge. In `CLR_ASYNC` mode it forces the state to zero at once. Stages can be chained into a wider synchronous counter with no extra gates. Each stage's `tc_out` drives the next stage's `cnt_en_b`, and all stages share `cnt_en_a`. In synchronous-clear mode, a chosen count can be decoded into `clr_n` to build a modulo-N counter.

Top module: `cascade_counter`

## Requirements
- R1: With `clr_n`, `load_n`, `cnt_en_a` and `cnt_en_b` all high, `q` increases by one on each rising edge.
- R2: With `clr_n` and `load_n` high and either count enable low, `q` holds its value across the edge.
- R3: With `clr_n` high and `load_n` low, `q` takes the value of `din` on the next rising edge, whatever the levels of the count enables.
- R4: `tc_out` is high exactly when `cnt_en_b` is high and `q` is all ones. `cnt_en_a` has no effect on it.
- R5: Counting from the all-ones value gives zero, and `tc_out` then goes low.
- R6: In `CLR_SYNC` mode, a low `clr_n` leaves `q` unchanged until the next rising edge, then makes it zero, whatever the levels of the enables.
- R7: In `CLR_ASYNC` mode, a low `clr_n` makes `q` zero at once, with no clock edge needed.
- R8: Priority is clear first, then load, then count, then hold. Clear overrides a simultaneous load, and load overrides a simultaneous count.
- R9: Two stages chained as described form a counter of twice the width. Its combined value equals the number of enabled edges since clear, modulo 2^(2W), and the upper stage's `tc_out` is high at the all-ones combined value.
- R10: In `CLR_SYNC` mode, feeding back `clr_n` low when `q` equals 9 gives the repeating sequence 0 through 9.
- R11: A width below 1 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Active-low clear; its timing is set by `CLR_MODE` |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en_a | input | 1 | Local count enable |
| cnt_en_b | input | 1 | Chain count enable; also gates `tc_out` |
| din | input | W | Parallel load data |
| q | output | W | Counter state |
| tc_out | output | 1 | Terminal count: `cnt_en_b` high and `q` all ones |

## Verification
Load, count, hold and synchronous clear settle on the first rising edge after the inputs are driven. The driver applies inputs on the falling edge and queues the value expected after the next rising edge. The monitor compares a quarter period after that rising edge. `tc_out` is combinational from `q` and `cnt_en_b`, so it is compared in the same sample, against the enable level that is still applied. Asynchronous clear, and the unchanged state before a synchronous clear's edge, are checked one time unit after `clr_n` falls, with no edge in between.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   typedef enum logic {
      CLR_SYNC  = 1'b0,
      CLR_ASYNC = 1'b1
   } clr_mode_e;
endpackage

// File: rtl/cnt_next.sv
// Next-state selection with look-ahead increment. Priority: clear, load, count, hold.
module cnt_next #(
   parameter int W = 4
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] din,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         run,
   output logic [W-1:0] nxt,
   output logic         full
);
   logic [W-1:0] tgl;

   // Toggle enables: bit i flips when every lower bit is one.
   always_comb begin
      logic acc;
      acc = 1'b1;
      for (int i = 0; i < W; i++) begin
         tgl[i] = acc;
         acc    = acc & cur[i];
      end
      full = acc;
   end

   always_comb begin
      if (!clr_n)       nxt = '0;
      else if (!load_n) nxt = din;
      else if (run)     nxt = cur ^ tgl;
      else              nxt = cur;
   end
endmodule

// File: rtl/cnt_state.sv
// State register; the clear variant is chosen by parameter.
module cnt_state #(
   parameter int                W        = 4,
   parameter cnt_pkg::clr_mode_e CLR_MODE = cnt_pkg::CLR_SYNC
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] cur
);
   generate
      if (CLR_MODE == cnt_pkg::CLR_ASYNC) begin : g_async
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            cur <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/cnt_carry.sv
// Terminal-count decode, gated by the chain enable only.
module cnt_carry (
   input  logic full,
   input  logic en_chain,
   output logic tc
);
   assign tc = full & en_chain;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
   parameter int                W        = 4,
   parameter cnt_pkg::clr_mode_e CLR_MODE = cnt_pkg::CLR_SYNC
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         cnt_en_a,
   input  logic         cnt_en_b,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         tc_out
);
   generate
      if (W < 1) begin : g_bad_width
         $fatal(1, "cascade_counter: W must be at least 1"); // R11
      end
   endgenerate

   logic [W-1:0] nxt;
   logic         full;
   logic         run;

   assign run = cnt_en_a & cnt_en_b;

   cnt_next #(.W(W)) u_next (
      .cur(q), .din(din), .clr_n(clr_n), .load_n(load_n),
      .run(run), .nxt(nxt), .full(full)
   );

   cnt_state #(.W(W), .CLR_MODE(CLR_MODE)) u_state (
      .clk(clk), .clr_n(clr_n), .nxt(nxt), .cur(q)
   );

   cnt_carry u_carry (
      .full(full), .en_chain(cnt_en_b), .tc(tc_out)
   );
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
   parameter int                W        = 4,
   parameter cnt_pkg::clr_mode_e CLR_MODE = cnt_pkg::CLR_SYNC
) (
   input logic         clk,
   input logic         clr_n,
   input logic         load_n,
   input logic         cnt_en_a,
   input logic         cnt_en_b,
   input logic [W-1:0] din,
   input logic [W-1:0] q,
   input logic         tc_out
);
   localparam bit IS_ASYNC = (CLR_MODE == cnt_pkg::CLR_ASYNC);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   // Armed once a clear has been sampled; the state is unknown before that.
   logic armed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

   logic async_hit;
   assign async_hit = IS_ASYNC && !clr_n;

   AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> q == '0);                                                   // R6
   AST_CLR_OVER_LOAD: assert property (@(posedge clk) disable iff (!armed)
      (!clr_n && !load_n) |=> q == '0);                                      // R8
   AST_LOAD: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> (async_hit || q == $past(din)));                // R3
   AST_COUNT: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_a && cnt_en_b) |=>
         (async_hit || q == W'($past(q) + 1'b1)));                           // R1
   AST_HOLD: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !(cnt_en_a && cnt_en_b)) |=> (async_hit || $stable(q))); // R2
   AST_WRAP: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_a && cnt_en_b && q == TOP) |=> (async_hit || q == '0)); // R5
   AST_TC_NEEDS: assert property (@(posedge clk) disable iff (!armed)
      tc_out |-> (cnt_en_b && q == TOP));                                    // R4
   AST_TC_GIVES: assert property (@(posedge clk) disable iff (!armed)
      (cnt_en_b && q == TOP) |-> tc_out);                                    // R4

   generate
      if (IS_ASYNC) begin : g_async_chk
         AST_CLR_NOW: assert property (@(posedge clk) disable iff (!armed)
            !clr_n |-> q == '0);                                             // R7
      end
   endgenerate
endmodule

bind cascade_counter cascade_counter_chk #(.W(W), .CLR_MODE(CLR_MODE)) u_chk (
   .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_a(cnt_en_a),
   .cnt_en_b(cnt_en_b), .din(din), .q(q), .tc_out(tc_out)
);

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;
   localparam int CLK_P = 10;
   localparam int W = 4;

   typedef struct {
      logic [W-1:0] q;
      logic         tc;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------- u0: synchronous clear, scoreboard ----------
   logic s_clr_n = 1'b1, s_load_n = 1'b1, s_a = 1'b0, s_b = 1'b0;
   logic [W-1:0] s_din = '0;
   logic [W-1:0] s_q;
   logic         s_tc;
   cascade_counter #(.W(W), .CLR_MODE(cnt_pkg::CLR_SYNC)) u0 (
      .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .cnt_en_a(s_a),
      .cnt_en_b(s_b), .din(s_din), .q(s_q), .tc_out(s_tc));

   exp_t sb[$];
   logic [W-1:0] model_q = '0;

   task automatic drive(input logic c, input logic l, input logic a, input logic b,
                        input logic [W-1:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      s_clr_n = c; s_load_n = l; s_a = a; s_b = b; s_din = d;
      if (!c)          model_q = '0;
      else if (!l)     model_q = d;
      else if (a && b) model_q = model_q + 1'b1;
      e.q = model_q;
      e.tc = b && (model_q == {W{1'b1}});
      e.tag = tag;
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      #(CLK_P/4);
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(s_q == e.q, {e.tag, " q"}, int'(s_q), int'(e.q));
         check(s_tc == e.tc, {e.tag, " tc_out"}, int'(s_tc), int'(e.tc));
      end
   end

   // ---------- u1: asynchronous clear ----------
   logic a_clr_n = 1'b1, a_load_n = 1'b1, a_a = 1'b0, a_b = 1'b0;
   logic [W-1:0] a_din = '0;
   logic [W-1:0] a_q;
   logic         a_tc;
   cascade_counter #(.W(W), .CLR_MODE(cnt_pkg::CLR_ASYNC)) u1 (
      .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .cnt_en_a(a_a),
      .cnt_en_b(a_b), .din(a_din), .q(a_q), .tc_out(a_tc));

   // ---------- u2/u3: two-stage chain ----------
   logic c_clr_n = 1'b1, c_en = 1'b0;
   logic [W-1:0] lo_q, hi_q;
   logic lo_tc, hi_tc;
   cascade_counter #(.W(W), .CLR_MODE(cnt_pkg::CLR_SYNC)) u2 (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en_a(c_en),
      .cnt_en_b(1'b1), .din('0), .q(lo_q), .tc_out(lo_tc));
   cascade_counter #(.W(W), .CLR_MODE(cnt_pkg::CLR_SYNC)) u3 (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en_a(c_en),
      .cnt_en_b(lo_tc), .din('0), .q(hi_q), .tc_out(hi_tc));

   // ---------- u4: divide-by-10 via decoded clear ----------
   logic m_rst_n = 1'b1;
   logic [W-1:0] m_q;
   logic m_tc;
   logic m_clr_n;
   assign m_clr_n = m_rst_n & ~(m_q == 4'd9);
   cascade_counter #(.W(W), .CLR_MODE(cnt_pkg::CLR_SYNC)) u4 (
      .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .cnt_en_a(1'b1),
      .cnt_en_b(1'b1), .din('0), .q(m_q), .tc_out(m_tc));

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      // u0 sequence: clear, load 12, count through wrap, inhibit.
      drive(0, 1, 1, 1, 4'd0,  "R6 reset clear");
      drive(1, 0, 0, 0, 4'd12, "R3 load with enables low");
      drive(1, 1, 1, 1, 4'd0,  "R1 count 13");
      drive(1, 1, 1, 1, 4'd0,  "R1 count 14");
      drive(1, 1, 1, 1, 4'd0,  "R4 count 15 tc high");
      drive(1, 1, 1, 1, 4'd0,  "R5 wrap to 0");
      drive(1, 1, 1, 1, 4'd0,  "R1 count 1");
      drive(1, 1, 1, 1, 4'd0,  "R1 count 2");
      drive(1, 1, 0, 1, 4'd0,  "R2 hold en_a low");
      drive(1, 1, 1, 0, 4'd0,  "R2 hold en_b low");
      drive(1, 0, 1, 0, 4'd15, "R4 load 15 en_b low");
      drive(1, 1, 0, 1, 4'd0,  "R4 en_a low tc high");
      drive(0, 0, 1, 1, 4'd7,  "R8 clear over load");
      drive(1, 0, 1, 1, 4'd9,  "R8 load over count");
      drive(1, 1, 1, 1, 4'd0,  "R1 count 10");
      drive(0, 1, 1, 1, 4'd0,  "R6 sync clear");
      #1 check(s_q == 4'd10, "R6 q unchanged before edge", int'(s_q), 10);
      drive(1, 1, 0, 0, 4'd0,  "R2 idle after clear");
      repeat (2) @(negedge clk);

      // u1: asynchronous clear.
      @(negedge clk);
      a_clr_n = 1'b0;
      #1 check(a_q == 4'd0, "R7 async clear at once", int'(a_q), 0);
      @(negedge clk);
      a_clr_n = 1'b1; a_load_n = 1'b0; a_din = 4'd5;
      @(negedge clk);
      check(a_q == 4'd5, "R3 async-mode load", int'(a_q), 5);
      a_load_n = 1'b1; a_a = 1'b1; a_b = 1'b1;
      repeat (2) @(negedge clk);
      check(a_q == 4'd7, "R1 async-mode count", int'(a_q), 7);
      #2 a_clr_n = 1'b0; a_load_n = 1'b0; a_din = 4'd3;
      #1 check(a_q == 4'd0, "R7 async clear mid-cycle", int'(a_q), 0);
      @(negedge clk);
      check(a_q == 4'd0, "R8 async clear over load", int'(a_q), 0);
      a_clr_n = 1'b1; a_load_n = 1'b1; a_a = 1'b0; a_b = 1'b0;

      // u2/u3: chained stages.
      @(negedge clk);
      c_clr_n = 1'b0;
      @(negedge clk);
      c_clr_n = 1'b1; c_en = 1'b1;
      repeat (255) @(negedge clk);
      check({hi_q, lo_q} == 8'd255, "R9 chain at 255", int'({hi_q, lo_q}), 255);
      check(hi_tc == 1'b1, "R9 upper tc at 255", int'(hi_tc), 1);
      @(negedge clk);
      check({hi_q, lo_q} == 8'd0, "R9 chain wrap", int'({hi_q, lo_q}), 0);
      repeat (44) @(negedge clk);
      check({hi_q, lo_q} == 8'd44, "R9 chain at 300", int'({hi_q, lo_q}), 44);
      c_en = 1'b0;
      repeat (3) @(negedge clk);
      check({hi_q, lo_q} == 8'd44, "R9 chain hold", int'({hi_q, lo_q}), 44);

      // u4: modulo ten.
      m_rst_n = 1'b0;
      @(negedge clk);
      m_rst_n = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         @(negedge clk);
         check(m_q == 4'(k % 10), "R10 divide-by-10", int'(m_q), k % 10);
      end

      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule